// File: doc/BRIEF.md
# Transmit Phase-Align Buffer with Recentering

This block sits between a host that delivers one character per cycle of its own input clock and a transmitter that consumes one character per cycle of the internal reference (character) clock. The two clocks run at the same nominal rate, but their phase may wander over voltage and temperature. A small dual-clock buffer takes up that wander. The write side stores every arriving character in an eight-entry ring. The read side takes characters out at the reference rate. The write pointer crosses into the read domain as a Gray code through a two-flop synchronizer.

When the read side is released from centering, it places its pointer two entries behind the synchronized write pointer. If the measured separation later reaches 0 (underflow) or 4 (overflow), a sticky error is raised. From then on the output carries a fixed error character every cycle. The error clears in one of two ways. The first is that the active-low realign input, which is asynchronous and synchronized internally, is held low. The second applies only when atomic word-sync mode is enabled: the read side sees a character tagged as part of a word-sync sequence. In that case it recenters on the spot, and a few characters may be repeated or skipped. When the host input is already clocked by the reference clock at single rate, a bypass mode skips the ring and registers the input directly on the reference clock for lower latency.

Top module: `pab_tx_align`

## Requirements
- R1: While `rst_n` is low, and for at least the first reference-clock cycle after it rises, `out_word_o` equals ERR_WORD (default 10'h2A5) and `err_o` is low.
- R2: With both clocks at the same rate, every written character appears on `out_word_o` exactly once and in write order (each value is the previous one plus one for an incrementing input).
- R3: When the input clock runs persistently faster than the reference clock, `err_o` rises.
- R4: When the input clock runs persistently slower than the reference clock, `err_o` rises.
- R5: Once set, `err_o` stays high after the clocks return to equal rates, unless realign, an atomic word-sync clear or bypass occurs.
- R6: In every cycle with `err_o` high, `out_word_o` equals ERR_WORD.
- R7: When `realign_n_i` is sampled low on two consecutive reference-clock edges, `err_o` drops and `out_word_o` carries ERR_WORD while it stays low. After release, characters again flow in order.
- R8: With `atomic_ws_i` high, a character written with `in_wsync_i` high clears the error and recenters the buffer, and in-order flow resumes.
- R9: With `atomic_ws_i` low, characters written with `in_wsync_i` high have no effect on a pending error.
- R10: With `bypass_i` high, `out_word_o` equals the `in_word_i` value sampled at the previous reference-clock edge, and `err_o` is low.
- R11: After `bypass_i` falls, the buffer resumes in-order flow from freshly centered pointers without raising an error.
- R12: The pointers are centered two entries apart. The error is raised while the synchronized separation is within the valid range, so no misordered character is delivered before `err_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both clock domains |
| wr_clk_i | input | 1 | Host input clock; writes the ring |
| rd_clk_i | input | 1 | Reference character clock; reads the ring |
| bypass_i | input | 1 | 1 = input already on the reference clock at single rate; ring skipped |
| atomic_ws_i | input | 1 | 1 = word-sync characters may clear an error by recentering |
| realign_n_i | input | 1 | Asynchronous active-low recenter request |
| in_word_i | input | DW | Character from the host |
| in_wsync_i | input | 1 | Marks the character as part of a word-sync sequence |
| out_word_o | output | DW | Character toward the transmitter, reference-clock domain |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The properties assume that `bypass_i` and `atomic_ws_i` only change between reference-clock edges and are stable across the edge that samples them. They also assume that the host writes one character on every input-clock cycle, so the ring is never left idle. The stimulus changes the mode inputs on the falling reference edge. It drives the data and the word-sync tag on the falling input edge. It holds realign low for several reference cycles. Clock drift is applied only until the error appears, and equal rates are restored before any stickiness or recovery is judged.

// File: rtl/pab_pkg.sv
package pab_pkg;
    // stages used on every clock-domain crossing of the block
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_ALIGN = 2'd0,
        ST_RUN   = 2'd1,
        ST_ERR   = 2'd2
    } rd_state_e;
endpackage

// File: rtl/pab_sync.sv
module pab_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_regs_t;

    sync_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.chain[STAGES-1];
endmodule

// File: rtl/pab_wr_side.sv
module pab_wr_side #(
    parameter int DW    = 10,
    parameter int DEPTH = 8
) (
    input  logic                       wr_clk,
    input  logic                       rst_n,
    input  logic [DW-1:0]              word_i,
    input  logic                       wsync_i,
    output logic [DEPTH-1:0][DW:0]     ent_o,
    output logic [$clog2(DEPTH):0]     wgray_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW:0] mem;
        logic [PW-1:0]          ptr;
        logic [PW-1:0]          gray;
    } wr_regs_t;

    wr_regs_t w_d, w_q;
    logic [PW-1:0] nptr;

    always_comb begin
        w_d  = w_q;
        nptr = w_q.ptr + PW'(1);
        w_d.mem[w_q.ptr[AW-1:0]] = {wsync_i, word_i};
        w_d.ptr  = nptr;
        w_d.gray = nptr ^ (nptr >> 1);
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign ent_o   = w_q.mem;
    assign wgray_o = w_q.gray;
endmodule

// File: rtl/pab_rd_ctrl.sv
module pab_rd_ctrl
    import pab_pkg::*;
#(
    parameter int          DW       = 10,
    parameter int          DEPTH    = 8,
    parameter logic [DW-1:0] ERR_WORD = 10'h2A5
) (
    input  logic                       rd_clk,
    input  logic                       rst_n,
    input  logic                       bypass_i,
    input  logic                       atomic_i,
    input  logic                       hold_i,
    input  logic [$clog2(DEPTH):0]     wgray_i,
    input  logic [DEPTH-1:0][DW:0]     ent_i,
    input  logic [DW-1:0]              byp_word_i,
    output logic [DW-1:0]              out_word_o,
    output logic                       err_o,
    output rd_state_e                  st_o,
    output logic [$clog2(DEPTH):0]     rd_ptr_o,
    output logic [$clog2(DEPTH):0]     sep_o
);
    localparam int AW     = $clog2(DEPTH);
    localparam int PW     = AW + 1;
    localparam int CENTER = DEPTH / 4;
    localparam int LIMIT  = DEPTH / 2;

    typedef struct packed {
        rd_state_e     st;
        logic [PW-1:0] rd_ptr;
        logic [DW-1:0] out;
        logic          err;
    } rd_regs_t;

    rd_regs_t      r_d, r_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] sep;
    logic [PW-1:0] centred;
    logic [DW:0]   rd_ent;
    logic          sep_bad;

    // Gray to binary on the synchronized write pointer
    always_comb begin
        wbin[PW-1] = wgray_i[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_i[i];
        end
    end

    always_comb begin
        sep     = wbin - r_q.rd_ptr;
        centred = wbin - PW'(CENTER);
        sep_bad = (int'($signed(sep)) <= 0) || (int'($signed(sep)) >= LIMIT);
        rd_ent  = ent_i[r_q.rd_ptr[AW-1:0]];

        r_d        = r_q;
        r_d.rd_ptr = r_q.rd_ptr + PW'(1);

        if (bypass_i) begin
            r_d.st     = ST_ALIGN;
            r_d.rd_ptr = centred;
            r_d.out    = byp_word_i;
            r_d.err    = 1'b0;
        end else if (hold_i) begin
            r_d.st     = ST_ALIGN;
            r_d.rd_ptr = centred;
            r_d.out    = ERR_WORD;
            r_d.err    = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ALIGN, ST_RUN: begin
                    if (sep_bad) begin
                        r_d.st  = ST_ERR;
                        r_d.out = ERR_WORD;
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st  = ST_RUN;
                        r_d.out = rd_ent[DW-1:0];
                        r_d.err = 1'b0;
                    end
                end
                ST_ERR: begin
                    r_d.out = ERR_WORD;
                    if (atomic_i && rd_ent[DW]) begin
                        r_d.st     = ST_RUN;
                        r_d.rd_ptr = centred;
                        r_d.err    = 1'b0;
                    end else begin
                        r_d.st  = ST_ERR;
                        r_d.err = 1'b1;
                    end
                end
                default: begin
                    r_d.st  = ST_ALIGN;
                    r_d.out = ERR_WORD;
                    r_d.err = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_ALIGN, rd_ptr: '0, out: ERR_WORD, err: 1'b0};
        else        r_q <= r_d;
    end

    assign out_word_o = r_q.out;
    assign err_o      = r_q.err;
    assign st_o       = r_q.st;
    assign rd_ptr_o   = r_q.rd_ptr;
    assign sep_o      = sep;
endmodule

// File: rtl/pab_tx_align.sv
module pab_tx_align
    import pab_pkg::*;
#(
    parameter int            DW       = 10,
    parameter int            DEPTH    = 8,
    parameter logic [DW-1:0] ERR_WORD = 10'h2A5
) (
    input  logic          rst_n,
    input  logic          wr_clk_i,
    input  logic          rd_clk_i,
    input  logic          bypass_i,
    input  logic          atomic_ws_i,
    input  logic          realign_n_i,
    input  logic [DW-1:0] in_word_i,
    input  logic          in_wsync_i,
    output logic [DW-1:0] out_word_o,
    output logic          err_o
);
    localparam int PW = $clog2(DEPTH) + 1;

    logic [DEPTH-1:0][DW:0] ent;
    logic [PW-1:0]          wgray;
    logic [PW-1:0]          wgray_rd;
    logic                   rn_sync;
    logic                   hold_align;
    rd_state_e              st;
    logic [PW-1:0]          rd_ptr;
    logic [PW-1:0]          sep;

    pab_wr_side #(.DW(DW), .DEPTH(DEPTH)) wr_i (
        .wr_clk  (wr_clk_i),
        .rst_n   (rst_n),
        .word_i  (in_word_i),
        .wsync_i (in_wsync_i),
        .ent_o   (ent),
        .wgray_o (wgray)
    );

    pab_sync #(.W(PW), .STAGES(SYNC_STAGES)) wptr_sync_i (
        .clk   (rd_clk_i),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_rd)
    );

    // resets to 0, so centering is held right after reset
    pab_sync #(.W(1), .STAGES(SYNC_STAGES)) realign_sync_i (
        .clk   (rd_clk_i),
        .rst_n (rst_n),
        .d     (realign_n_i),
        .q     (rn_sync)
    );

    assign hold_align = ~rn_sync;

    pab_rd_ctrl #(.DW(DW), .DEPTH(DEPTH), .ERR_WORD(ERR_WORD)) rd_i (
        .rd_clk     (rd_clk_i),
        .rst_n      (rst_n),
        .bypass_i   (bypass_i),
        .atomic_i   (atomic_ws_i),
        .hold_i     (hold_align),
        .wgray_i    (wgray_rd),
        .ent_i      (ent),
        .byp_word_i (in_word_i),
        .out_word_o (out_word_o),
        .err_o      (err_o),
        .st_o       (st),
        .rd_ptr_o   (rd_ptr),
        .sep_o      (sep)
    );
endmodule

// File: rtl/pab_tx_align_chk.sv
module pab_tx_align_chk
    import pab_pkg::*;
#(
    parameter int            DW       = 10,
    parameter int            PW       = 4,
    parameter logic [DW-1:0] ERR_WORD = 10'h2A5
) (
    input logic          rd_clk,
    input logic          rst_n,
    input logic          bypass_i,
    input logic          atomic_i,
    input logic          hold,
    input logic          err_o,
    input logic [DW-1:0] out_word_o,
    input rd_state_e     st,
    input logic [PW-1:0] rd_ptr,
    input logic [PW-1:0] sep
);
    localparam int LIMIT = (1 << (PW - 1)) / 2;

    p_run_step_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) == ST_RUN) |-> (rd_ptr - $past(rd_ptr)) == PW'(1));

    p_err_sticky_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (err_o && !hold && !bypass_i && !atomic_i) |=> err_o);

    p_err_word_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        err_o |-> out_word_o == ERR_WORD);

    p_align_blank_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (hold && !bypass_i) |=> (!err_o && out_word_o == ERR_WORD));

    p_bypass_clean_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        bypass_i |=> !err_o);

    p_sep_guard_r12: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (st == ST_RUN && !hold && !bypass_i &&
         (int'($signed(sep)) <= 0 || int'($signed(sep)) >= LIMIT)) |=> err_o);
endmodule

bind pab_tx_align pab_tx_align_chk #(.DW(DW), .PW(PW), .ERR_WORD(ERR_WORD)) chk_i (
    .rd_clk     (rd_clk_i),
    .rst_n      (rst_n),
    .bypass_i   (bypass_i),
    .atomic_i   (atomic_ws_i),
    .hold       (hold_align),
    .err_o      (err_o),
    .out_word_o (out_word_o),
    .st         (st),
    .rd_ptr     (rd_ptr),
    .sep        (sep)
);

// File: tb/pab_tx_align_tb_top.sv
`timescale 1ns/1ps
module pab_tx_align_tb_top;
    localparam logic [9:0] ERRW = 10'h2A5;

    logic       rst_n = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_clk = 1'b0;
    logic       bypass = 1'b0;
    logic       atomic = 1'b0;
    logic       realign_n = 1'b1;
    logic       hold_in = 1'b0;
    logic [9:0] byp_word = '0;
    logic [9:0] cnt = '0;
    logic       ws_on = 1'b0;
    logic       wsync_q = 1'b0;
    logic [9:0] in_word;
    logic [9:0] out_word;
    logic       err;
    real        wr_half = 2.0;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    assign in_word = hold_in ? byp_word : cnt;

    pab_tx_align dut_i (
        .rst_n       (rst_n),
        .wr_clk_i    (wr_clk),
        .rd_clk_i    (rd_clk),
        .bypass_i    (bypass),
        .atomic_ws_i (atomic),
        .realign_n_i (realign_n),
        .in_word_i   (in_word),
        .in_wsync_i  (wsync_q),
        .out_word_o  (out_word),
        .err_o       (err)
    );

    initial forever #2 rd_clk = ~rd_clk;
    initial begin
        #1.3;
        forever #(wr_half) wr_clk = ~wr_clk;
    end

    always @(negedge wr_clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 10'd1;
        wsync_q <= ws_on;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // watch n reference cycles; count in-order and out-of-order pairs
    task automatic watch(input int n, input bit stop_on_err,
                         output int good, output int bad, output bit saw_err);
        logic [9:0] prev;
        bit         have = 1'b0;
        good = 0; bad = 0; saw_err = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            if (err) begin
                saw_err = 1'b1;
                if (stop_on_err) break;
                have = 1'b0;
            end else begin
                if (have && prev != ERRW && out_word != ERRW) begin
                    if (out_word == prev + 10'd1) good++;
                    else bad++;
                end
                prev = out_word;
                have = 1'b1;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge rd_clk);
        check(out_word == ERRW, "R1 out in reset", out_word, ERRW);
        check(err == 1'b0, "R1 err in reset", err, 0);
        rst_n = 1'b1;
        @(negedge rd_clk);
        check(out_word == ERRW && err == 1'b0, "R1 first cycle after reset", out_word, ERRW);
    endtask

    task automatic t_stream(input string tag);
        int g, b; bit e;
        repeat (8) @(negedge rd_clk);
        watch(200, 1'b0, g, b, e);
        check(b == 0 && g > 150 && !e, tag, b, 0);
    endtask

    task automatic drift_to_err(input real half, input string tag);
        int g, b; bit e;
        wr_half = half;
        watch(400, 1'b1, g, b, e);
        wr_half = 2.0;
        check(e, tag, e, 1);
        check(b == 0, "R12 no misorder before error", b, 0);
    endtask

    task automatic t_sticky();
        int bad_err = 0, bad_word = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge rd_clk);
            if (!err) bad_err++;
            if (out_word != ERRW) bad_word++;
        end
        check(bad_err == 0, "R5 error stays set", bad_err, 0);
        check(bad_word == 0, "R6 error word forced", bad_word, 0);
    endtask

    task automatic t_realign();
        @(negedge rd_clk);
        realign_n = 1'b0;
        repeat (3) @(negedge rd_clk);
        check(err == 1'b0 && out_word == ERRW, "R7 centering clears error", {err, out_word}, ERRW);
        repeat (4) @(negedge rd_clk);
        realign_n = 1'b1;
        t_stream("R7 flow after realign");
    endtask

    task automatic send_wsync();
        @(negedge wr_clk);
        ws_on = 1'b1;
        repeat (24) @(negedge wr_clk);
        ws_on = 1'b0;
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic t_wsync_ignored();
        @(negedge rd_clk);
        atomic = 1'b0;
        send_wsync();
        check(err == 1'b1 && out_word == ERRW, "R9 wsync without atomic", err, 1);
    endtask

    task automatic t_wsync_clear();
        @(negedge rd_clk);
        atomic = 1'b1;
        send_wsync();
        check(err == 1'b0, "R8 wsync clears error", err, 0);
        t_stream("R8 flow after wsync");
        @(negedge rd_clk);
        atomic = 1'b0;
    endtask

    task automatic t_bypass();
        logic [9:0] v;
        int bad_d = 0, bad_e = 0;
        @(negedge rd_clk);
        bypass  = 1'b1;
        hold_in = 1'b1;
        v = 10'h013;
        byp_word = v;
        for (int i = 0; i < 20; i++) begin
            @(negedge rd_clk);
            if (out_word != v) bad_d++;
            if (err) bad_e++;
            v = v * 10'd37 + 10'd5;
            byp_word = v;
        end
        check(bad_d == 0, "R10 bypass data path", bad_d, 0);
        check(bad_e == 0, "R10 bypass no error", bad_e, 0);
    endtask

    task automatic t_leave_bypass();
        @(negedge rd_clk);
        bypass  = 1'b0;
        hold_in = 1'b0;
        t_stream("R11 flow after bypass");
    endtask

    initial begin
        repeat (3) @(negedge rd_clk);
        t_reset();
        t_stream("R2 in-order flow");
        drift_to_err(1.8, "R3 overflow sets error");
        t_sticky();
        t_realign();
        drift_to_err(2.2, "R4 underflow sets error");
        t_wsync_ignored();
        t_wsync_clear();
        drift_to_err(1.8, "R3 overflow before bypass");
        t_bypass();
        t_leave_bypass();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge rd_clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule